// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block sits between a requester and a single memory port and carries out atomic operations one at a time. A request names an operation, an access size (32-bit word or 64-bit doubleword), a byte address and a 64-bit operand. For an arithmetic or logical atomic, the unit reads the location and keeps the old value as its result. It then combines the old value with the operand and writes the outcome back to the same address. From the read request to the write acknowledge, it holds a lock line that tells the memory side to admit no other access.

The unit also serves a load-reserved / store-conditional pair. A load-reserved reads the location and records one reservation on its 8-byte granule. A store-conditional writes its operand only while that reservation is still valid for the same granule. Every store-conditional clears the reservation, and so does an external write into the reserved granule, which is reported on a separate observe port. Misaligned addresses and unknown operation codes are refused with an error response, and memory is not touched.

Top module: `amo_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mem_req` and `mem_lock` are 0.
- R2: Arithmetic and logical atomics return the old memory value as `rsp_data` and write the combined value back to the request address. For a doubleword op the full 64 bits are used, and `rsp_err` is 0.
- R3: Operation codes on `req_op`: 0 add, 1 swap (write operand), 2 and, 3 or, 4 xor. Each writes the named combination of old value and operand.
- R4: Codes 5 signed minimum, 6 signed maximum, 7 unsigned minimum, 8 unsigned maximum. For a word (`req_dword`=0), both values are taken as 32-bit quantities: signed for 5 and 6, unsigned for 7 and 8.
- R5: A word access reads and writes only the addressed 32-bit half, carried in bits 31:0 of `mem_rdata`/`mem_wdata` with `mem_dword`=0. The returned old value is sign-extended from bit 31 to 64 bits.
- R6: For codes 0 to 8, `mem_lock` is 1 in every cycle from the first read request up to the write acknowledge. During that time `req_ready` stays 0.
- R7: Code 9 (load-reserved) reads the location and returns it (sign-extended for a word). It writes nothing and records a reservation on the 8-byte granule of the address.
- R8: Code 10 (store-conditional) with a valid reservation on the same granule writes the operand and returns 0.
- R9: A store-conditional without such a reservation writes nothing and returns 1. Every store-conditional, passing or failing, clears the reservation.
- R10: A pulse on `snoop_we` whose `snoop_addr` falls in the reserved granule clears the reservation.
- R11: A request whose address is not aligned to its size (4 bytes for a word, 8 for a doubleword), or whose code is above 10, gets `rsp_err`=1 and `rsp_data`=0, with no memory request.
- R12: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request taken at this edge |
| req_op | input | 4 | Operation code |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 64 | Operand |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Old value, or store-conditional status |
| rsp_err | output | 1 | Request refused |
| mem_req | output | 1 | Memory access held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_dword | output | 1 | Access size |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 64 | Write data |
| mem_lock | output | 1 | No other access may intervene |
| mem_rvalid | input | 1 | Access acknowledge; read data valid |
| mem_rdata | input | 64 | Read data |
| snoop_we | input | 1 | External write observed |
| snoop_addr | input | ADDR_W | Address of the external write |

## Verification
The bench goes after word operations on both halves of a doubleword, with junk in the unused half of the read data. A unit that skips sign extension, or compares the full 64 bits, returns the wrong value or picks the wrong minimum or maximum. Signed and unsigned extremes such as 0x80000000 against 1 are chosen so that a signed/unsigned mix-up writes the other operand. Store-conditional is run after a load-reserved, again after it without a new reservation, after an external write into the granule, and after an external write elsewhere. A design that kept the reservation, or cleared it on an unrelated write, writes when it should not or fails when it should pass. Misaligned and unknown requests catch a design that still reaches memory, and a per-cycle watch on the lock catches a dropped lock between read and write.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int XW = 64;
    localparam int HW = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SWAP = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MIN  = 4'd5,
        OP_MAX  = 4'd6,
        OP_MINU = 4'd7,
        OP_MAXU = 4'd8,
        OP_LR   = 4'd9,
        OP_SC   = 4'd10
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_RESP
    } amo_st_e;

    function automatic logic [XW-1:0] sext_half(input logic [XW-1:0] v);
        return {{(XW-HW){v[HW-1]}}, v[HW-1:0]};
    endfunction
endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_e         op_i,
    input  logic            dword_i,
    input  logic [XW-1:0]   old_i,
    input  logic [XW-1:0]   opd_i,
    output logic [XW-1:0]   res_o
);
    logic [XW-1:0] a, b;
    logic          lt_s, lt_u;

    always_comb begin
        a    = dword_i ? old_i : sext_half(old_i);
        b    = dword_i ? opd_i : sext_half(opd_i);
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
        unique case (op_i)
            OP_ADD:  res_o = a + b;
            OP_SWAP: res_o = b;
            OP_AND:  res_o = a & b;
            OP_OR:   res_o = a | b;
            OP_XOR:  res_o = a ^ b;
            OP_MIN:  res_o = lt_s ? a : b;
            OP_MAX:  res_o = lt_s ? b : a;
            OP_MINU: res_o = lt_u ? a : b;
            OP_MAXU: res_o = lt_u ? b : a;
            default: res_o = a;
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int ADDR_W  = 16,
    parameter int GRAN_LG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] set_addr_i,
    input  logic              sc_i,
    input  logic              snoop_we_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic              hit_o
);
    localparam int TW = ADDR_W - GRAN_LG;

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
    } resv_t;

    resv_t r_d, r_q;
    logic  snoop_hit;

    always_comb begin
        r_d       = r_q;
        snoop_hit = snoop_we_i && r_q.vld && (snoop_addr_i[ADDR_W-1:GRAN_LG] == r_q.tag);
        hit_o     = r_q.vld && (chk_addr_i[ADDR_W-1:GRAN_LG] == r_q.tag);
        if (set_i) begin
            r_d.vld = 1'b1;
            r_d.tag = set_addr_i[ADDR_W-1:GRAN_LG];
        end else if (sc_i || snoop_hit) begin
            r_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_i && !set_i) |=> !hit_o); // R9
    AST_SNOOP_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_we_i && !set_i && (snoop_addr_i[ADDR_W-1:GRAN_LG] == chk_addr_i[ADDR_W-1:GRAN_LG]))
        |=> !(hit_o && $stable(chk_addr_i))); // R10
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int GRAN_LG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic              req_dword,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XW-1:0]     req_data,
    output logic              rsp_valid,
    output logic [XW-1:0]     rsp_data,
    output logic              rsp_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XW-1:0]     mem_wdata,
    output logic              mem_lock,
    input  logic              mem_rvalid,
    input  logic [XW-1:0]     mem_rdata,
    input  logic              snoop_we,
    input  logic [ADDR_W-1:0] snoop_addr
);
    typedef struct packed {
        amo_st_e           st;
        amo_op_e           op;
        logic              dw;
        logic [ADDR_W-1:0] addr;
        logic [XW-1:0]     opd;
        logic [XW-1:0]     old;
        logic [XW-1:0]     wdat;
        logic [XW-1:0]     rsp;
        logic              err;
    } ctl_t;

    ctl_t          c_d, c_q;
    logic [XW-1:0] alu_res;
    logic          resv_hit, resv_set, resv_sc;
    logic          misal, bad_op, is_atomic;

    amo_alu u_alu (
        .op_i    (c_q.op),
        .dword_i (c_q.dw),
        .old_i   (c_q.old),
        .opd_i   (c_q.opd),
        .res_o   (alu_res)
    );

    amo_resv #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_resv (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (resv_set),
        .set_addr_i   (c_q.addr),
        .sc_i         (resv_sc),
        .snoop_we_i   (snoop_we),
        .snoop_addr_i (snoop_addr),
        .chk_addr_i   (req_addr),
        .hit_o        (resv_hit)
    );

    always_comb begin
        c_d      = c_q;
        resv_set = 1'b0;
        resv_sc  = 1'b0;
        misal    = req_dword ? (|req_addr[2:0]) : (|req_addr[1:0]);
        bad_op   = req_op > OP_SC;
        unique case (c_q.st)
            ST_IDLE: if (req_valid) begin
                c_d.op   = amo_op_e'(req_op);
                c_d.dw   = req_dword;
                c_d.addr = req_addr;
                c_d.opd  = req_data;
                c_d.err  = 1'b0;
                c_d.rsp  = '0;
                if (misal || bad_op) begin
                    c_d.err = 1'b1;
                    c_d.st  = ST_RESP;
                end else if (amo_op_e'(req_op) == OP_SC) begin
                    resv_sc = 1'b1;
                    if (resv_hit) begin
                        c_d.wdat = req_data;
                        c_d.st   = ST_WRITE;
                    end else begin
                        c_d.rsp = {{(XW-1){1'b0}}, 1'b1};
                        c_d.st  = ST_RESP;
                    end
                end else begin
                    c_d.st = ST_READ;
                end
            end
            ST_READ: if (mem_rvalid) begin
                c_d.old = c_q.dw ? mem_rdata : sext_half(mem_rdata);
                c_d.rsp = c_d.old;
                if (c_q.op == OP_LR) begin
                    resv_set = 1'b1;
                    c_d.st   = ST_RESP;
                end else begin
                    c_d.st = ST_CALC;
                end
            end
            ST_CALC: begin
                c_d.wdat = alu_res;
                c_d.st   = ST_WRITE;
            end
            ST_WRITE: if (mem_rvalid) c_d.st = ST_RESP;
            default:  c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        is_atomic = (c_q.op != OP_LR) && (c_q.op != OP_SC);
        req_ready = c_q.st == ST_IDLE;
        rsp_valid = c_q.st == ST_RESP;
        rsp_data  = c_q.rsp;
        rsp_err   = c_q.err;
        mem_req   = (c_q.st == ST_READ) || (c_q.st == ST_WRITE);
        mem_we    = c_q.st == ST_WRITE;
        mem_dword = c_q.dw;
        mem_addr  = c_q.addr;
        mem_wdata = c_q.wdat;
        mem_lock  = is_atomic &&
                    ((c_q.st == ST_READ) || (c_q.st == ST_CALC) || (c_q.st == ST_WRITE));
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !(mem_we && mem_rvalid)) |=> mem_lock); // R6
    AST_LOCK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> !req_ready); // R6
    AST_BAD_REQ_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_dword ? (|req_addr[2:0]) : (|req_addr[1:0])))
        |=> (!mem_req && rsp_valid && rsp_err)); // R11
    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && !mem_dword && (c_q.op != OP_SC))
        |-> (rsp_data[XW-1:HW] == {(XW-HW){rsp_data[HW-1]}})); // R5
endmodule

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    localparam int CLK_NS = 10;
    localparam int AW     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [3:0]    req_op = '0;
    logic          req_dword = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_data = '0;
    logic          rsp_valid, rsp_err;
    logic [63:0]   rsp_data;
    logic          mem_req, mem_we, mem_dword, mem_lock;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          snoop_we = 1'b0;
    logic [AW-1:0] snoop_addr = '0;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem  [16];
    logic [63:0] refm [16];
    bit          res_v = 0;
    logic [AW-4:0] res_g = '0;

    always #(CLK_NS/2) clk = ~clk;

    amo_unit #(.ADDR_W(AW)) u0 (.*);

    // memory: acknowledges one cycle after a request appears
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            if (mem_we) begin
                if (mem_dword) mem[mem_addr[6:3]] <= mem_wdata;
                else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
                else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
            end else begin
                if (mem_dword) mem_rdata <= mem[mem_addr[6:3]];
                else mem_rdata <= {32'hA5C3_F00D,
                                   mem_addr[2] ? mem[mem_addr[6:3]][63:32] : mem[mem_addr[6:3]][31:0]};
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    // behavioural reference: returns expected response, updates refm / reservation
    function automatic logic [64:0] model(input logic [3:0] op, input bit dw,
                                          input logic [AW-1:0] a, input logic [63:0] d);
        logic [63:0] old, x, y, nv;
        int i;
        i = int'(a[6:3]);
        if ((dw ? a[2:0] != 0 : a[1:0] != 0) || op > 4'd10) return {1'b1, 64'd0};
        if (op == 4'd10) begin
            bit ok;
            ok = res_v && (res_g == a[AW-1:3]);
            res_v = 0;
            if (!ok) return {1'b0, 64'd1};
            nv = d;
        end else begin
            old = dw ? refm[i] : sx(a[2] ? {32'd0, refm[i][63:32]} : refm[i]);
            if (op == 4'd9) begin
                res_v = 1; res_g = a[AW-1:3];
                return {1'b0, old};
            end
            x = old; y = dw ? d : sx(d);
            case (op)
                4'd0: nv = x + y;
                4'd1: nv = y;
                4'd2: nv = x & y;
                4'd3: nv = x | y;
                4'd4: nv = x ^ y;
                4'd5: nv = ($signed(x) < $signed(y)) ? x : y;
                4'd6: nv = ($signed(x) > $signed(y)) ? x : y;
                4'd7: nv = (x < y) ? x : y;
                default: nv = (x > y) ? x : y;
            endcase
        end
        if (dw) refm[i] = nv;
        else if (a[2]) refm[i][63:32] = nv[31:0];
        else refm[i][31:0] = nv[31:0];
        return {1'b0, (op == 4'd10) ? 64'd0 : old};
    endfunction

    task automatic run(input string tag, input logic [3:0] op, input bit dw,
                       input logic [AW-1:0] a, input logic [63:0] d);
        logic [64:0] exp;
        int n = 0, memcyc = 0, lockgap = 0, rdy = 0;
        exp = model(op, dw, a, d);
        @(negedge clk);
        req_op = op; req_dword = dw; req_addr = a; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 50) begin
            if (mem_req) memcyc++;
            if (!mem_lock) lockgap++;
            if (req_ready) rdy++;
            @(negedge clk);
            n++;
        end
        check({tag, " response seen"}, 64'(rsp_valid), 64'd1);
        check({tag, " err"}, 64'(rsp_err), 64'(exp[64]));
        check({tag, " data"}, rsp_data, exp[63:0]);
        for (int k = 0; k < 16; k++)
            if (mem[k] !== refm[k]) check({tag, " memory"}, mem[k], refm[k]);
        if (exp[64]) check({tag, " R11 no memory access"}, 64'(memcyc), 64'd0);
        if (op <= 4'd8 && !exp[64]) begin
            check({tag, " R6 lock continuous"}, 64'(lockgap), 64'd0);
            check({tag, " R6 not ready while busy"}, 64'(rdy), 64'd0);
        end
        @(negedge clk);
        check({tag, " R12 single pulse"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic ext_write(input logic [AW-1:0] a, input logic [63:0] v);
        @(negedge clk);
        snoop_we = 1'b1; snoop_addr = a;
        mem[a[6:3]] = v; refm[a[6:3]] = v;
        if (res_v && res_g == a[AW-1:3]) res_v = 0;
        @(negedge clk);
        snoop_we = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            mem[k]  = 64'h0123_4567_89AB_CDEF ^ (64'(k) << 40);
            refm[k] = mem[k];
        end
        repeat (3) @(negedge clk);
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 mem_lock", 64'(mem_lock), 64'd0);
        rst_n = 1'b1;

        run("R2 R3 add dword", 4'd0, 1, 16'h0008, 64'h0000_0001_0000_0001);
        run("R3 swap dword",  4'd1, 1, 16'h0010, 64'hFEED_FACE_CAFE_BEEF);
        run("R3 and word lo", 4'd2, 0, 16'h0018, 64'h0000_0000_F0F0_F0F0);
        run("R3 or word hi",  4'd3, 0, 16'h001C, 64'h0000_0000_0000_8001);
        run("R3 xor dword",   4'd4, 1, 16'h0020, 64'hFFFF_FFFF_FFFF_FFFF);
        mem[5] = 64'h0000_0001_8000_0000; refm[5] = mem[5];
        run("R4 min word signed",  4'd5, 0, 16'h0028, 64'h0000_0000_0000_0001);
        mem[5] = 64'h0000_0001_8000_0000; refm[5] = mem[5];
        run("R4 max word signed",  4'd6, 0, 16'h0028, 64'h0000_0000_0000_0001);
        mem[5] = 64'h0000_0001_8000_0000; refm[5] = mem[5];
        run("R4 minu word",  4'd7, 0, 16'h0028, 64'h0000_0000_0000_0001);
        mem[5] = 64'h0000_0001_8000_0000; refm[5] = mem[5];
        run("R4 maxu word",  4'd8, 0, 16'h0028, 64'h0000_0000_0000_0001);
        run("R4 min dword",  4'd5, 1, 16'h0030, 64'h8000_0000_0000_0000);
        run("R4 maxu dword", 4'd8, 1, 16'h0038, 64'h8000_0000_0000_0000);
        run("R5 add word hi sext", 4'd0, 0, 16'h0034, 64'h0000_0000_7FFF_FFFF);
        run("R5 add word overflow", 4'd0, 0, 16'h0040, 64'h0000_0000_8000_0000);

        run("R7 lr word", 4'd9, 0, 16'h0044, 64'd0);
        run("R8 sc pass same granule", 4'd10, 1, 16'h0040, 64'h1111_2222_3333_4444);
        run("R9 sc fail after sc", 4'd10, 1, 16'h0040, 64'h5555_6666_7777_8888);
        run("R7 lr dword", 4'd9, 1, 16'h0048, 64'd0);
        run("R9 sc fail other granule", 4'd10, 1, 16'h0050, 64'h9999);
        run("R9 sc fail cleared by failing sc", 4'd10, 1, 16'h0048, 64'h9999);
        run("R7 lr again", 4'd9, 1, 16'h0048, 64'd0);
        ext_write(16'h0060, 64'hABCD);
        run("R10 sc pass after unrelated write", 4'd10, 0, 16'h004C, 64'h0000_0000_1234_5678);
        run("R7 lr before snoop", 4'd9, 1, 16'h0058, 64'd0);
        ext_write(16'h005C, 64'h7777);
        run("R10 sc fail after snoop", 4'd10, 1, 16'h0058, 64'h4242);

        run("R11 misaligned dword", 4'd0, 1, 16'h0004, 64'd5);
        run("R11 misaligned word", 4'd1, 0, 16'h0002, 64'd5);
        run("R11 unknown op", 4'd12, 1, 16'h0008, 64'd5);
        run("R2 add after error", 4'd0, 1, 16'h0008, 64'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule